// File: doc/BRIEF.md
# Setup Payload Ring Address Sequencer

This block sits between the packet receiver of a USB device control endpoint and system memory. It turns each received SETUP payload into word writes on a simple memory port. Software programs a ring base address. Successive payloads then go into three consecutive slots of that ring, and the live write pointer can be read back at any time. The pointer is not a copy of the configuration: it is the address that the next word write will use.

A payload is framed by a start strobe and an end strobe. Its data arrives as 32-bit words, and each word carries a count of valid bytes. Storage is always done in whole words, so a short payload takes as many words as its bytes round up to. The pointer moves by exactly the number of bytes written. When a fourth payload starts after three stored ones, the pointer is reloaded with the programmed base. It is not moved back by a fixed ring size. Because of this, a run of short payloads can never leave the pointer outside the ring. Payloads longer than the nominal 8 bytes are cut to 8 bytes and raise a sticky flag. A done pulse reports which slot each payload filled.

Top module: `setup_ring_addr_gen`

## Requirements
- R1: After reset the pointer reads 0, the overflow flag is 0, and neither a memory write nor a done pulse is issued.
- R2: A base write sets the pointer to the written value in the next cycle. It clears the stored-payload count to zero and aborts any payload in progress. Data words that arrive in the same cycle as a base write are dropped.
- R3: Each accepted data word is presented on the memory port in the cycle after it was offered, at the address the pointer held when it was offered.
- R4: The pointer advances by 4 for each stored word. A payload of n bytes (n at most 8) stores ceil(n/4) words, so a 1- to 4-byte payload moves the pointer by 4 and a 5- to 8-byte payload moves it by 8.
- R5: A start strobe that arrives while three payloads are stored first reloads the pointer with the programmed base and clears the count. The new payload then goes to slot 0.
- R6: The pointer never leaves the range from base to base+24, inclusive, for any mix of payload lengths.
- R7: Word packing is little-endian. The valid-byte count (1 to 4) selects lanes: byte k sits at bits 8k+7..8k. Lanes at or above the count are written as zero.
- R8: Words after the second in a payload are not written and do not move the pointer, and they set the sticky overflow flag.
- R9: A clear strobe resets the overflow flag unless a truncation sets it in the same cycle. In that case setting wins.
- R10: The done pulse is one cycle wide. It appears two cycles after the end strobe is taken, which is one cycle after the last word write. It carries the filled slot index, and slots are used in the order 0, 1, 2.
- R11: Data words and end strobes offered while no payload is open cause no write and no pointer change. They also produce no done pulse.
- R12: A start strobe during an open payload discards that payload. The pointer returns to the start of the same slot, and the next payload overwrites that slot without using a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Software write strobe for the ring base |
| base_wr_data | input | ADDR_W | New ring base address |
| ovf_clr | input | 1 | Write-one strobe that clears the overflow flag |
| rx_start | input | 1 | Payload start strobe from the receiver |
| rx_word_valid | input | 1 | A payload word is offered this cycle |
| rx_word_data | input | 8*WORD_BYTES | Payload word, byte 0 in the low lane |
| rx_word_nbytes | input | clog2(WORD_BYTES+1) | Valid bytes in the offered word (1..WORD_BYTES) |
| rx_end | input | 1 | Payload end strobe, may coincide with the last word |
| mem_wr_en | output | 1 | Memory word write strobe |
| mem_wr_addr | output | ADDR_W | Byte address of the memory write |
| mem_wr_data | output | 8*WORD_BYTES | Packed, zero-filled write data |
| ptr_value | output | ADDR_W | Live write pointer |
| ovf_flag | output | 1 | Sticky oversize-payload flag |
| pkt_done | output | 1 | One-cycle pulse per completed payload |
| pkt_slot | output | clog2(SLOT_CNT) | Slot filled by the completed payload |

## Verification
The assertions assume the receiver behaves in a well-formed way. Start strobes come alone, with no data or end strobe in the same cycle. Every offered word carries a byte count from 1 to 4. A software base write is the only event that changes the ring base. The directed tasks drive every strobe at the falling edge and keep to these rules. The only exceptions are the R2, R11 and R12 scenarios, which deliberately offer words outside an open payload or start strobes inside one, and the design defines what happens in those cases.

// File: rtl/setup_ring_pkg.sv
package setup_ring_pkg;

   typedef enum logic {
      RX_IDLE = 1'b0,
      RX_OPEN = 1'b1
   } rx_state_e;

   function automatic logic lane_valid(input int unsigned nbytes, input int unsigned lane);
      return nbytes > lane;
   endfunction

endpackage

// File: rtl/sr_word_pack.sv
module sr_word_pack #(
   parameter int WORD_BYTES = 4,
   parameter int NB_W       = $clog2(WORD_BYTES + 1)
) (
   input  logic [8*WORD_BYTES-1:0] word_in,
   input  logic [NB_W-1:0]         nbytes,
   output logic [8*WORD_BYTES-1:0] word_out
);
   import setup_ring_pkg::*;

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      logic keep;
      always_comb keep = lane_valid(int'(nbytes), g);
      assign word_out[8*g +: 8] = keep ? word_in[8*g +: 8] : 8'h00;
   end

endmodule

// File: rtl/sr_pkt_track.sv
module sr_pkt_track #(
   parameter int SLOT_WORDS = 2,
   parameter int WCNT_W     = $clog2(SLOT_WORDS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_we,
   input  logic start_i,
   input  logic word_valid,
   input  logic end_i,
   output logic busy,
   output logic accept,
   output logic trunc_hit,
   output logic end_take
);
   import setup_ring_pkg::*;

   rx_state_e         st_q;
   logic [WCNT_W-1:0] wcnt_q;
   logic              live;
   logic              room;

   assign busy   = (st_q == RX_OPEN);
   assign live   = busy & ~base_we & ~start_i;
   assign room   = (wcnt_q < WCNT_W'(SLOT_WORDS));

   assign accept    = live & word_valid & room;
   assign trunc_hit = live & word_valid & ~room;
   assign end_take  = live & end_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         wcnt_q <= '0;
      end else if (base_we) begin
         st_q   <= RX_IDLE;
         wcnt_q <= '0;
      end else if (start_i) begin
         st_q   <= RX_OPEN;
         wcnt_q <= '0;
      end else begin
         if (accept) wcnt_q <= wcnt_q + 1'b1;
         if (end_take) st_q <= RX_IDLE;
      end
   end

   // R8: the per-payload word count never passes the slot size
   assert_word_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt_q <= WCNT_W'(SLOT_WORDS));

   // R8: a word offered to a full slot is not counted
   assert_trunc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trunc_hit |=> wcnt_q == $past(wcnt_q));

endmodule

// File: rtl/sr_ptr_ctrl.sv
module sr_ptr_ctrl #(
   parameter int ADDR_W     = 32,
   parameter int SLOT_CNT   = 3,
   parameter int WORD_BYTES = 4,
   parameter int RING_BYTES = 24,
   parameter int CNT_W      = $clog2(SLOT_CNT + 1),
   parameter int IDX_W      = $clog2(SLOT_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_wdata,
   input  logic              start_i,
   input  logic              busy_i,
   input  logic              end_take,
   input  logic              accept,
   output logic [ADDR_W-1:0] ptr_o,
   output logic [IDX_W-1:0]  slot_o
);
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] slot_ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  slot_q;
   logic              start_take;
   logic              restart;
   logic              wrap;

   assign start_take = start_i & ~base_we;
   assign restart    = start_take & busy_i;
   assign wrap       = start_take & ~busy_i & (cnt_q == CNT_W'(SLOT_CNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q     <= '0;
         ptr_q      <= '0;
         slot_ptr_q <= '0;
         cnt_q      <= '0;
         slot_q     <= '0;
      end else if (base_we) begin
         base_q     <= base_wdata;
         ptr_q      <= base_wdata;
         slot_ptr_q <= base_wdata;
         cnt_q      <= '0;
         slot_q     <= '0;
      end else if (restart) begin
         ptr_q      <= slot_ptr_q;
      end else if (wrap) begin
         ptr_q      <= base_q;
         slot_ptr_q <= base_q;
         cnt_q      <= '0;
         slot_q     <= '0;
      end else if (start_take) begin
         slot_ptr_q <= ptr_q;
         slot_q     <= cnt_q[IDX_W-1:0];
      end else begin
         if (accept) ptr_q <= ptr_q + ADDR_W'(WORD_BYTES);
         if (end_take && cnt_q != CNT_W'(SLOT_CNT)) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ptr_o  = ptr_q;
   assign slot_o = slot_q;

   // R2: a base write reloads the live pointer and clears the count
   assert_base_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      base_we |=> (ptr_q == $past(base_wdata)) && (cnt_q == '0));

   // R4: one stored word moves the pointer by one word
   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ptr_q == $past(ptr_q) + ADDR_W'(WORD_BYTES));

   // R5: the wrap lands exactly on the programmed base
   assert_wrap_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (ptr_q == base_q) && (slot_q == '0));

   // R6: the pointer stays inside the ring
   assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q - base_q) <= ADDR_W'(RING_BYTES));

   // R12: a restart rewinds to the start of the same slot
   assert_restart_rewind_R12: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (ptr_q == slot_ptr_q) && $stable(slot_q));

endmodule

// File: rtl/setup_ring_addr_gen.sv
module setup_ring_addr_gen #(
   parameter int ADDR_W     = 32,
   parameter int SLOT_CNT   = 3,
   parameter int SLOT_BYTES = 8,
   parameter int WORD_BYTES = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             base_wr_en,
   input  logic [ADDR_W-1:0]                base_wr_data,
   input  logic                             ovf_clr,
   input  logic                             rx_start,
   input  logic                             rx_word_valid,
   input  logic [8*WORD_BYTES-1:0]          rx_word_data,
   input  logic [$clog2(WORD_BYTES+1)-1:0]  rx_word_nbytes,
   input  logic                             rx_end,
   output logic                             mem_wr_en,
   output logic [ADDR_W-1:0]                mem_wr_addr,
   output logic [8*WORD_BYTES-1:0]          mem_wr_data,
   output logic [ADDR_W-1:0]                ptr_value,
   output logic                             ovf_flag,
   output logic                             pkt_done,
   output logic [$clog2(SLOT_CNT)-1:0]      pkt_slot
);
   localparam int DATA_W     = 8 * WORD_BYTES;
   localparam int NB_W       = $clog2(WORD_BYTES + 1);
   localparam int SLOT_WORDS = SLOT_BYTES / WORD_BYTES;
   localparam int WCNT_W     = $clog2(SLOT_WORDS + 1);
   localparam int RING_BYTES = SLOT_CNT * SLOT_BYTES;
   localparam int CNT_W      = $clog2(SLOT_CNT + 1);
   localparam int IDX_W      = $clog2(SLOT_CNT);

   if (SLOT_CNT < 2) begin : g_bad_slots
      $error("SLOT_CNT must be at least 2");
   end
   if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("WORD_BYTES must be a power of two");
   end
   if (SLOT_BYTES < WORD_BYTES || (SLOT_BYTES % WORD_BYTES) != 0) begin : g_bad_slot_bytes
      $error("SLOT_BYTES must be a whole number of words");
   end
   if (ADDR_W < $clog2(RING_BYTES + 1)) begin : g_bad_addr
      $error("ADDR_W too narrow for the ring");
   end

   logic              busy;
   logic              accept;
   logic              trunc_hit;
   logic              end_take;
   logic [ADDR_W-1:0] ptr_q;
   logic [IDX_W-1:0]  slot_q;
   logic [DATA_W-1:0] packed_word;

   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              end_q;
   logic              done_q;
   logic [IDX_W-1:0]  done_slot_q;
   logic              ovf_q;

   sr_pkt_track #(
      .SLOT_WORDS (SLOT_WORDS),
      .WCNT_W     (WCNT_W)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_we    (base_wr_en),
      .start_i    (rx_start),
      .word_valid (rx_word_valid),
      .end_i      (rx_end),
      .busy       (busy),
      .accept     (accept),
      .trunc_hit  (trunc_hit),
      .end_take   (end_take)
   );

   sr_ptr_ctrl #(
      .ADDR_W     (ADDR_W),
      .SLOT_CNT   (SLOT_CNT),
      .WORD_BYTES (WORD_BYTES),
      .RING_BYTES (RING_BYTES),
      .CNT_W      (CNT_W),
      .IDX_W      (IDX_W)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_we    (base_wr_en),
      .base_wdata (base_wr_data),
      .start_i    (rx_start),
      .busy_i     (busy),
      .end_take   (end_take),
      .accept     (accept),
      .ptr_o      (ptr_q),
      .slot_o     (slot_q)
   );

   sr_word_pack #(
      .WORD_BYTES (WORD_BYTES),
      .NB_W       (NB_W)
   ) u_pack (
      .word_in  (rx_word_data),
      .nbytes   (rx_word_nbytes),
      .word_out (packed_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         we_q <= accept;
         if (accept) begin
            addr_q <= ptr_q;
            data_q <= packed_word;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_q       <= 1'b0;
         done_q      <= 1'b0;
         done_slot_q <= '0;
      end else begin
         end_q  <= end_take;
         done_q <= end_q;
         if (end_q) done_slot_q <= slot_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ovf_q <= 1'b0;
      else if (trunc_hit) ovf_q <= 1'b1;
      else if (ovf_clr)   ovf_q <= 1'b0;
   end

   assign mem_wr_en   = we_q;
   assign mem_wr_addr = addr_q;
   assign mem_wr_data = data_q;
   assign ptr_value   = ptr_q;
   assign ovf_flag    = ovf_q;
   assign pkt_done    = done_q;
   assign pkt_slot    = done_slot_q;

   // R3: an accepted word is written at the pointer it saw, one cycle later
   assert_write_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> mem_wr_en && (mem_wr_addr == $past(ptr_q)));

   // R9: truncation sets the flag even if a clear arrives with it
   assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trunc_hit |=> ovf_flag);

   // R9: a clear without truncation drops the flag
   assert_ovf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !trunc_hit) |=> !ovf_flag);

   // R10: the done pulse follows the taken end strobe by two cycles
   assert_done_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      end_take |=> ##1 pkt_done);

   // R10: the done pulse lasts a single cycle per end strobe
   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && !$past(end_take)) |=> !pkt_done);

   // R11: words offered with no open payload produce no write
   assert_idle_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rx_word_valid) |=> !mem_wr_en);

endmodule

// File: tb/setup_ring_addr_gen_tb.sv
module setup_ring_addr_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_wr_en = 1'b0;
   logic [31:0] base_wr_data = '0;
   logic        ovf_clr = 1'b0;
   logic        rx_start = 1'b0;
   logic        rx_word_valid = 1'b0;
   logic [31:0] rx_word_data = '0;
   logic [2:0]  rx_word_nbytes = '0;
   logic        rx_end = 1'b0;
   logic        mem_wr_en;
   logic [31:0] mem_wr_addr;
   logic [31:0] mem_wr_data;
   logic [31:0] ptr_value;
   logic        ovf_flag;
   logic        pkt_done;
   logic [1:0]  pkt_slot;

   always #10 clk = ~clk;

   setup_ring_addr_gen u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .base_wr_en     (base_wr_en),
      .base_wr_data   (base_wr_data),
      .ovf_clr        (ovf_clr),
      .rx_start       (rx_start),
      .rx_word_valid  (rx_word_valid),
      .rx_word_data   (rx_word_data),
      .rx_word_nbytes (rx_word_nbytes),
      .rx_end         (rx_end),
      .mem_wr_en      (mem_wr_en),
      .mem_wr_addr    (mem_wr_addr),
      .mem_wr_data    (mem_wr_data),
      .ptr_value      (ptr_value),
      .ovf_flag       (ovf_flag),
      .pkt_done       (pkt_done),
      .pkt_slot       (pkt_slot)
   );

   int checks = 0;
   int failures = 0;

   logic [31:0] m_base = '0;
   logic [31:0] m_ptr = '0;
   int          m_cnt = 0;
   logic        m_ovf = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_ring(input string req);
      check(ptr_value == m_ptr, req, ptr_value, m_ptr);
      check((ptr_value - m_base) <= 32'd24, "R6 pointer within ring", ptr_value - m_base, 32'd24);
   endtask

   task automatic write_base(input logic [31:0] v);
      @(negedge clk);
      base_wr_en = 1'b1;
      base_wr_data = v;
      @(negedge clk);
      base_wr_en = 1'b0;
      m_base = v;
      m_ptr = v;
      m_cnt = 0;
      check(ptr_value == v, "R2 base write reloads pointer", ptr_value, v);
   endtask

   // sends one framed payload and checks every write, the done pulse and the pointer
   task automatic send_pkt(input int nbytes, input logic [7:0] seed, input bit restart);
      int nw;
      int slot;
      nw = (nbytes + 3) / 4;
      @(negedge clk);
      rx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0;
      if (!restart && m_cnt == 3) begin
         m_ptr = m_base;
         m_cnt = 0;
      end
      slot = m_cnt;
      if (nw == 0) begin
         rx_end = 1'b1;
         @(negedge clk);
      end
      for (int i = 0; i < nw; i++) begin
         logic [31:0] drv;
         logic [31:0] exp;
         int nb;
         nb = (nbytes - 4*i > 4) ? 4 : nbytes - 4*i;
         for (int j = 0; j < 4; j++) begin
            if (j < nb) begin
               drv[8*j +: 8] = seed + 8'(4*i + j);
               exp[8*j +: 8] = seed + 8'(4*i + j);
            end else begin
               drv[8*j +: 8] = 8'hA5;
               exp[8*j +: 8] = 8'h00;
            end
         end
         rx_word_valid = 1'b1;
         rx_word_data = drv;
         rx_word_nbytes = 3'(nb);
         rx_end = (i == nw - 1);
         @(negedge clk);
         if (i < 2) begin
            check(mem_wr_en == 1'b1, "R3 word write issued", 32'(mem_wr_en), 32'd1);
            check(mem_wr_addr == m_ptr, "R3 write address", mem_wr_addr, m_ptr);
            check(mem_wr_data == exp, "R7 packed data", mem_wr_data, exp);
            m_ptr = m_ptr + 32'd4;
         end else begin
            check(mem_wr_en == 1'b0, "R8 extra word dropped", 32'(mem_wr_en), 32'd0);
            m_ovf = 1'b1;
         end
      end
      rx_word_valid = 1'b0;
      rx_end = 1'b0;
      check(pkt_done == 1'b0, "R10 done not early", 32'(pkt_done), 32'd0);
      @(negedge clk);
      check(pkt_done == 1'b1, "R10 done pulse", 32'(pkt_done), 32'd1);
      check(pkt_slot == 2'(slot), "R10 slot index", 32'(pkt_slot), 32'(slot));
      m_cnt++;
      check_ring("R4 pointer after payload");
      check(ovf_flag == m_ovf, "R8 overflow flag", 32'(ovf_flag), 32'(m_ovf));
      @(negedge clk);
      check(pkt_done == 1'b0, "R10 done one cycle wide", 32'(pkt_done), 32'd0);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(ptr_value == 32'd0, "R1 reset pointer", ptr_value, 32'd0);
      check(ovf_flag == 1'b0, "R1 reset overflow", 32'(ovf_flag), 32'd0);
      check(mem_wr_en == 1'b0, "R1 reset no write", 32'(mem_wr_en), 32'd0);
      check(pkt_done == 1'b0, "R1 reset no done", 32'(pkt_done), 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_mixed_wrap;
      write_base(32'h0000_1000);
      send_pkt(8, 8'h10, 1'b0);
      send_pkt(3, 8'h20, 1'b0);
      send_pkt(5, 8'h30, 1'b0);
      check(ptr_value == 32'h0000_1014, "R4 short payloads round to words", ptr_value, 32'h0000_1014);
      send_pkt(8, 8'h40, 1'b0);
      check(m_ptr == 32'h0000_1008, "R5 wrap lands on base", m_ptr, 32'h0000_1008);
   endtask

   task automatic t_tiny_wrap;
      write_base(32'h0000_2040);
      send_pkt(1, 8'h50, 1'b0);
      send_pkt(2, 8'h60, 1'b0);
      send_pkt(4, 8'h70, 1'b0);
      send_pkt(1, 8'h80, 1'b0);
      check(ptr_value == 32'h0000_2044, "R5 wrap after short payloads", ptr_value, 32'h0000_2044);
      send_pkt(6, 8'h90, 1'b0);
      send_pkt(8, 8'hA0, 1'b0);
      send_pkt(7, 8'hB0, 1'b0);
   endtask

   task automatic t_oversize;
      write_base(32'h0000_3000);
      send_pkt(12, 8'hC0, 1'b0);
      check(ovf_flag == 1'b1, "R8 overflow set", 32'(ovf_flag), 32'd1);
      send_pkt(8, 8'hD0, 1'b0);
      check(ovf_flag == 1'b1, "R9 overflow sticky", 32'(ovf_flag), 32'd1);
      @(negedge clk);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      m_ovf = 1'b0;
      check(ovf_flag == 1'b0, "R9 overflow cleared", 32'(ovf_flag), 32'd0);
      send_pkt(16, 8'hE0, 1'b0);
      send_pkt(0, 8'h00, 1'b0);
   endtask

   task automatic t_stray;
      logic [31:0] p;
      p = ptr_value;
      @(negedge clk);
      rx_word_valid = 1'b1;
      rx_word_data = 32'hDEAD_BEEF;
      rx_word_nbytes = 3'd4;
      rx_end = 1'b1;
      @(negedge clk);
      check(mem_wr_en == 1'b0, "R11 stray word not written", 32'(mem_wr_en), 32'd0);
      rx_word_valid = 1'b0;
      rx_end = 1'b0;
      @(negedge clk);
      check(pkt_done == 1'b0, "R11 stray end no done", 32'(pkt_done), 32'd0);
      check(ptr_value == p, "R11 pointer unchanged", ptr_value, p);
   endtask

   task automatic t_base_abort;
      write_base(32'h0000_4000);
      send_pkt(8, 8'h11, 1'b0);
      @(negedge clk);
      rx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0;
      rx_word_valid = 1'b1;
      rx_word_data = 32'h0403_0201;
      rx_word_nbytes = 3'd4;
      @(negedge clk);
      check(mem_wr_addr == 32'h0000_4008, "R3 write before abort", mem_wr_addr, 32'h0000_4008);
      base_wr_en = 1'b1;
      base_wr_data = 32'h0000_5000;
      @(negedge clk);
      base_wr_en = 1'b0;
      check(mem_wr_en == 1'b0, "R2 word during base write dropped", 32'(mem_wr_en), 32'd0);
      check(ptr_value == 32'h0000_5000, "R2 abort reloads pointer", ptr_value, 32'h0000_5000);
      @(negedge clk);
      rx_word_valid = 1'b0;
      check(mem_wr_en == 1'b0, "R2 aborted payload closed", 32'(mem_wr_en), 32'd0);
      m_base = 32'h0000_5000;
      m_ptr = m_base;
      m_cnt = 0;
      send_pkt(8, 8'h22, 1'b0);
   endtask

   task automatic t_restart;
      logic [31:0] s;
      s = m_ptr;
      @(negedge clk);
      rx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0;
      rx_word_valid = 1'b1;
      rx_word_data = 32'h1111_1111;
      rx_word_nbytes = 3'd4;
      @(negedge clk);
      rx_word_valid = 1'b0;
      check(mem_wr_addr == s, "R12 partial write at slot start", mem_wr_addr, s);
      send_pkt(8, 8'h33, 1'b1);
      check(m_ptr == s + 32'd8, "R12 restart reused slot", m_ptr, s + 32'd8);
      send_pkt(4, 8'h44, 1'b0);
      send_pkt(8, 8'h55, 1'b0);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_mixed_wrap();
      t_tiny_wrap();
      t_oversize();
      t_stray();
      t_base_abort();
      t_restart();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule